// File: doc/BRIEF.md
# Serial-Bus Register Target for a Paired 16-bit Port Bank

This block is the two-wire serial-bus target in front of a 16-bit port expander's register bank. It receives SCL and SDA sampled by the system clock. Both lines pass through a synchronizer and a glitch filter. The block then finds START, repeated START and STOP conditions on the filtered lines.

It answers one 7-bit address. The upper five bits of that address are fixed and the lower two come from strap inputs. The first byte after a write address is a register pointer. Later bytes are written into the bank or read out of it through a plain index/data port. After every data byte the pointer steps to the other register of its pair, so a burst goes back and forth inside one pair.

The target only pulls SDA low and otherwise releases it. It never stretches the clock. While the active-low reset is held, the line filters, the bus sequencer and the pointer all stay at their defaults.

Top module: `i2c_pair_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 1,1,1,0,1,strap_a[1],strap_a[0] (MSB first); bit 0 of that byte is the direction, 1 for read and 0 for write. Any other address gets no acknowledge, and the target ignores the rest of that transfer.
- R2: In a write transfer, the byte after the address is acknowledged and loads the 3-bit pointer from its bits 2:0. Pointer values 0..7 select input0, input1, output0, output1, invert0, invert1, direction0, direction1. Bits 7:3 are ignored, so 0x0B selects index 3.
- R3: Every later write byte is acknowledged and shown on wr_byte with the current pointer on wr_idx, during a single-cycle wr_stb pulse.
- R4: After each data byte, whether written or read, the pointer changes only its bit 0. For example, index 3 is followed by 2, then by 3.
- R5: A transfer may hold any number of data bytes. A STOP ends it at any point, and bytes clocked after that STOP but before a new START get no acknowledge and cause no write.
- R6: A read is a write address with a pointer byte, then a repeated START, then the read address. Data is shifted out MSB first, starting at the register the pointer selects. SDA is released during the controller's acknowledge bit, and a not-acknowledge ends the read.
- R7: Writes while the pointer is 0 or 1 (the input registers) are acknowledged but raise no wr_stb.
- R8: While rst_n is low, SDA is released, wr_stb is low and the pointer returns to 0. A transfer that was in progress is dropped.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks has no effect. For example, a short low pulse on SDA while SCL is high is not taken as a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| strap_a | input | 2 | Low two address bits from straps |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_idx | output | 3 | Register index for reads (current pointer) |
| rd_byte | input | 8 | Register contents at rd_idx |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_idx | output | 3 | Register index for the write |
| wr_byte | output | 8 | Data for the write |

## Verification
Faults in the bit counter or the sequencer state show up at the very next acknowledge bit. SDA is either not pulled low where an acknowledge is due, or pulled low where the line must stay released, so the bench catches the error within nine SCL periods. A fault in the pointer toggle shows up on the second byte of any burst, which lands on the wrong register index or returns the wrong register contents. A filter that is too weak turns an SDA spike into a false START, so a later byte with a matching address gets an acknowledge where none should appear.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int DW   = 8;
    localparam int IDXW = 3;
    localparam int CNTW = $clog2(DW + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          line;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw};
        if (q.sync[1] != q.line) begin
            if (q.cnt == CW'(FILT_CYC - 1)) begin
                d.line = q.sync[1];
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clean = q.line;

    // R9
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.line) |-> ($past(q.sync[1]) == q.line));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign start_det = scl_q & scl & sda_q & ~sda;
    assign stop_det  = scl_q & scl & ~sda_q & sda;
    assign scl_rise  = ~scl_q & scl;
    assign scl_fall  = scl_q & ~scl;
endmodule

// File: rtl/i2c_pair_target.sv
module i2c_pair_target
    import i2c_tgt_pkg::*;
#(
    parameter int         FILT_CYC = 4,
    parameter logic [4:0] ADDR_HI  = 5'b11101
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    input  logic [1:0]      strap_a,
    output logic            sda_pull_low,
    output logic [IDXW-1:0] rd_idx,
    input  logic [DW-1:0]   rd_byte,
    output logic            wr_stb,
    output logic [IDXW-1:0] wr_idx,
    output logic [DW-1:0]   wr_byte
);
    localparam int NLINE = 2;

    typedef struct packed {
        tgt_state_e      st;
        logic [DW-1:0]   sh;
        logic [CNTW-1:0] cnt;
        logic            rw;
        logic            nack;
        logic [IDXW-1:0] ptr;
        logic            drv;
        logic            wr_en;
        logic [IDXW-1:0] wr_addr;
        logic [DW-1:0]   wr_data;
    } tgt_t;

    logic [NLINE-1:0] raw_lines, clean_lines;
    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < NLINE; g++) begin : g_filt
        i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = clean_lines[1];
    assign sda_f = clean_lines[0];

    logic start_det, stop_det, scl_rise, scl_fall;

    i2c_bus_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_f),
        .sda       (sda_f),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    tgt_t q, d;
    logic byte_done;
    assign byte_done = scl_fall && (q.cnt == CNTW'(DW));

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.drv = 1'b0;
        end else if (stop_det) begin
            d.st  = ST_IDLE;
            d.drv = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_f};
                        d.cnt = q.cnt + 1'b1;
                    end else if (byte_done) begin
                        d.drv = 1'b1;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[DW-1:1] == {ADDR_HI, strap_a}) begin
                                d.rw = q.sh[0];
                                d.st = ST_ADDR_ACK;
                            end else begin
                                d.drv = 1'b0;
                                d.st  = ST_IDLE;
                            end
                        end else if (q.st == ST_CMD) begin
                            d.ptr = q.sh[IDXW-1:0];
                            d.st  = ST_CMD_ACK;
                        end else begin
                            d.wr_en   = (q.ptr[IDXW-1:1] != '0);
                            d.wr_addr = q.ptr;
                            d.wr_data = q.sh;
                            d.ptr[0]  = ~q.ptr[0];
                            d.st      = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh  = rd_byte;
                            d.drv = ~rd_byte[DW-1];
                            d.st  = ST_RDATA;
                        end else begin
                            d.drv = 1'b0;
                            d.st  = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.drv = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == CNTW'(DW - 1)) begin
                            d.drv    = 1'b0;
                            d.ptr[0] = ~q.ptr[0];
                            d.st     = ST_RACK;
                        end else begin
                            d.sh  = {q.sh[DW-2:0], 1'b0};
                            d.drv = ~q.sh[DW-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda_f;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.sh  = rd_byte;
                            d.drv = ~rd_byte[DW-1];
                            d.cnt = '0;
                            d.st  = ST_RDATA;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.sh      <= '0;
            q.cnt     <= '0;
            q.rw      <= 1'b0;
            q.nack    <= 1'b1;
            q.ptr     <= '0;
            q.drv     <= 1'b0;
            q.wr_en   <= 1'b0;
            q.wr_addr <= '0;
            q.wr_data <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_low = q.drv;
    assign rd_idx       = q.ptr;
    assign wr_stb       = q.wr_en;
    assign wr_idx       = q.wr_addr;
    assign wr_byte      = q.wr_data;

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4
    ptr_pair_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (rd_idx == {wr_idx[IDXW-1:1], ~wr_idx[0]}));

    // R7
    no_input_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx[IDXW-1:1] != '0));

    // R5
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_low);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_low);
endmodule

// File: tb/i2c_pair_target_test.sv
module i2c_pair_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_pull_low, wr_stb;
    logic [2:0] rd_idx, wr_idx;
    logic [7:0] wr_byte, rd_byte;
    logic       sda_line;
    logic [7:0] bank [8];
    int         in_wr_cnt = 0;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;
    assign rd_byte  = bank[rd_idx];

    i2c_pair_target uut (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_m), .sda_in (sda_line),
        .strap_a (strap), .sda_pull_low (sda_pull_low), .rd_idx (rd_idx),
        .rd_byte (rd_byte), .wr_stb (wr_stb), .wr_idx (wr_idx), .wr_byte (wr_byte)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            if (wr_idx < 3'd2) in_wr_cnt <= in_wr_cnt + 1;
            else bank[wr_idx] <= wr_byte;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop;
        scl_m = 1'b0; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        scl_m = 1'b0; w(Q);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); ack_n = sda_line; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input logic give_nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0;
        end
        w(Q); sda_m = give_nack; scl_m = 1'b1; w(Q);
        check("R6 SDA released in controller ack slot", sda_pull_low, 1'b0);
        w(Q); scl_m = 1'b0; w(Q); sda_m = 1'b1;
    endtask

    task automatic t_reset_state;
        check("R8 SDA released in reset", sda_pull_low, 1'b0);
        check("R8 no strobe in reset", wr_stb, 1'b0);
        check("R8 pointer zero in reset", rd_idx, 3'd0);
    endtask

    task automatic t_write_pair;
        logic a;
        bus_start;
        send_byte(8'hEA, a); check("R1 address ack", a, 1'b0);
        send_byte(8'h03, a); check("R2 command ack", a, 1'b0);
        send_byte(8'h11, a); check("R3 data ack", a, 1'b0);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop;
        check("R4 output1 last write", bank[3], 8'h33);
        check("R4 output0 toggled write", bank[2], 8'h22);
    endtask

    task automatic t_write_dir_masked;
        logic a;
        bus_start;
        send_byte(8'hEA, a);
        send_byte(8'h0E, a); check("R2 masked command ack", a, 1'b0);
        send_byte(8'h0F, a);
        send_byte(8'hF0, a);
        send_byte(8'h55, a);
        send_byte(8'h66, a);
        bus_stop;
        check("R5 direction0 after four bytes", bank[6], 8'h55);
        check("R5 direction1 after four bytes", bank[7], 8'h66);
        bus_start;
        send_byte(8'hEA, a);
        send_byte(8'h0B, a);
        send_byte(8'h44, a);
        bus_stop;
        check("R2 0x0B selects index 3", bank[3], 8'h44);
    endtask

    task automatic t_addr_mismatch;
        logic a;
        bus_start;
        send_byte(8'hEC, a); check("R1 wrong strap NACK", a, 1'b1);
        send_byte(8'h04, a); check("R1 ignored after NACK", a, 1'b1);
        send_byte(8'h99, a);
        bus_stop;
        check("R1 no write after NACK", bank[4], 8'h00);
        strap = 2'b10;
        bus_start;
        send_byte(8'hEC, a); check("R1 new strap ack", a, 1'b0);
        send_byte(8'h05, a);
        send_byte(8'h5A, a);
        bus_stop;
        check("R1 write under new strap", bank[5], 8'h5A);
        strap = 2'b01;
    endtask

    task automatic t_input_write;
        logic a;
        bus_start;
        send_byte(8'hEA, a);
        send_byte(8'h00, a);
        send_byte(8'h12, a); check("R7 input write acked", a, 1'b0);
        send_byte(8'h34, a);
        bus_stop;
        check("R7 no strobe for input regs", in_wr_cnt, 0);
        check("R7 input0 unchanged", bank[0], 8'hA5);
    endtask

    task automatic t_read_pair;
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte(8'hEA, a);
        send_byte(8'h01, a);
        bus_start;
        send_byte(8'hEB, a); check("R6 read address ack", a, 1'b0);
        recv_byte(1'b0, b); check("R6 first read byte", b, 8'h3C);
        recv_byte(1'b0, b); check("R4 read toggles to input0", b, 8'hA5);
        recv_byte(1'b1, b); check("R4 read toggles back", b, 8'h3C);
        w(Q);
        check("R6 released after NACK", sda_pull_low, 1'b0);
        bus_stop;
    endtask

    task automatic t_stop_midway;
        logic a;
        bus_start;
        send_byte(8'hEA, a);
        send_byte(8'h02, a);
        send_byte(8'h77, a);
        bus_stop;
        check("R5 byte before stop written", bank[2], 8'h77);
        send_byte(8'h99, a); check("R5 NACK after stop", a, 1'b1);
        check("R5 no write after stop", bank[3], 8'h44);
        bus_stop;
    endtask

    task automatic t_reset_midway;
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte(8'hEA, a);
        send_byte(8'h05, a);
        rst_n = 1'b0; w(4);
        check("R8 released during reset", sda_pull_low, 1'b0);
        rst_n = 1'b1; w(Q);
        send_byte(8'hEE, a); check("R8 transfer dropped", a, 1'b1);
        check("R8 no write after reset", bank[5], 8'h5A);
        bus_stop;
        bus_start;
        send_byte(8'hEB, a);
        recv_byte(1'b1, b); check("R8 pointer back to 0", b, 8'hA5);
        bus_stop;
    endtask

    task automatic t_glitch;
        logic a;
        w(Q);
        sda_m = 1'b0; w(2); sda_m = 1'b1; w(Q);
        send_byte(8'hEA, a); check("R9 SDA spike not a START", a, 1'b1);
        bus_stop;
    endtask

    initial begin
        bank[0] = 8'hA5; bank[1] = 8'h3C; bank[2] = 8'hFF; bank[3] = 8'hFF;
        bank[4] = 8'h00; bank[5] = 8'h00; bank[6] = 8'hFF; bank[7] = 8'hFF;
        w(3);
        t_reset_state;
        rst_n = 1'b1; w(Q);
        t_write_pair;
        t_write_dir_masked;
        t_addr_mismatch;
        t_input_write;
        t_read_pair;
        t_stop_midway;
        t_reset_midway;
        t_glitch;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule